// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command pins of a DDR SDRAM from the device side. On every rising clock edge it samples clock-enable, the four active-low strobes, the bank bits and the address. It turns them into one decoded operation and keeps a state machine for each bank. Each bank is idle, open with a recorded row, or closing after a precharge.

The block reports each operation one cycle after the edge that sampled it. The report carries the operation code, the bank, the row or column (or the mode op-code), and the auto-precharge flag. It raises a one-cycle illegal flag for a command the current bank or burst state does not allow. An illegal command changes no state. Writes to the two mode registers are held on dedicated outputs.

A small burst tracker follows the most recent read or write. It has two jobs: it decides whether a burst-terminate is allowed, and it closes the bank when an auto-precharge burst ends.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: The strobes {cs_n, ras_n, cas_n, we_n} decode as follows: cs_n high is deselect, reported as op_code 0 (NOP), the same as LHHH. LLHH is ACTIVE (1). LHLH is READ (2). LHLL is WRITE (3). LHHL is burst-terminate (4). LLHL is PRECHARGE: code 5 with addr[10] low, or 6 (all banks) with addr[10] high. LLLH is refresh: code 7 with cke high, or 8 (self refresh) with cke low. LLLL is mode-register load (9). Deselect and NOP change no bank state and no mode register.
- R2: A legal ACTIVE moves bank `ba` to open and records addr as its row. open_rows[b*ADDR_W +: ADDR_W] holds bank b's row. bank_open bit b is high while bank b is open. op_addr reports the row.
- R3: PRECHARGE with addr[10] low closes only bank `ba`. With addr[10] high it closes every open bank whatever `ba` holds. A precharge to an idle or already closing bank does nothing and is not illegal.
- R4: READ and WRITE report addr[COL_W-1:0] as the column in op_addr, and addr[10] in op_ap. A burst lasts BURST_LEN/2 cycles. With auto-precharge, the bank begins closing at the edge that ends the burst. Without it, the bank stays open.
- R5: After a bank starts closing at edge p, an ACTIVE to that bank is illegal at edges p+1 to p+T_RP-1 and legal from edge p+T_RP.
- R6: Burst-terminate is legal only while a read burst issued without auto-precharge is running, and it ends that burst. In every other case it raises illegal: during an auto-precharge read, during any write burst, or with no burst running.
- R7: With cke low, every command other than deselect, NOP and refresh raises illegal and has no effect.
- R8: These commands raise illegal and leave every bank unchanged: an ACTIVE to an open or closing bank, a READ or WRITE to a bank that is not open, and a READ or WRITE while an auto-precharge burst is running.
- R9: A legal mode-register load writes addr into mode_reg when ba is 0, and into ext_mode_reg when ba[0]=1 and ba[1]=0. Any other ba value raises illegal and writes neither register.
- R10: All reported outputs are registered and show the command sampled at the previous rising edge. After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address, ba[0] is the low bank bit |
| addr | input | ADDR_W | Row, column, precharge-all flag or op-code |
| op_code | output | 4 | Decoded operation (R1 codes) |
| op_bank | output | BA_W | Bank of the operation, 0 when it has none |
| op_addr | output | ADDR_W | Row, column or op-code, else 0 |
| op_ap | output | 1 | Auto-precharge flag of a read or write |
| illegal | output | 1 | One-cycle illegal-command pulse |
| bank_open | output | NUM_BANKS | Per-bank open flag |
| open_rows | output | NUM_BANKS*ADDR_W | Recorded row of each bank |
| mode_reg | output | ADDR_W | Base mode register |
| ext_mode_reg | output | ADDR_W | Extended mode register |

## Verification
The operation report and the illegal flag are due one clock edge after a command is sampled. bank_open changes at that same edge for ACTIVE and PRECHARGE. An auto-precharge closes its bank BURST_LEN/2 edges after the READ or WRITE. A closing bank accepts ACTIVE again T_RP edges after the edge that closed it. The bench drives every command on a falling edge and reads the outputs at the next falling edge. Delayed effects are checked by issuing the exact number of intermediate commands, each of which is itself checked.

// File: rtl/sdcmd_pkg.sv
// Shared types for the SDRAM command tracker.
// Assumes: operation codes are visible at the top ports as 4-bit values.
package sdcmd_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ACT  = 4'd1,
        OP_RD   = 4'd2,
        OP_WR   = 4'd3,
        OP_BST  = 4'd4,
        OP_PRE  = 4'd5,
        OP_PREA = 4'd6,
        OP_AREF = 4'd7,
        OP_SREF = 4'd8,
        OP_LMR  = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_CLOSING = 2'd2
    } bank_e;

endpackage

// File: rtl/sdcmd_decode.sv
// Purely combinational strobe decoder.
// Turns the sampled strobes, cke and the precharge-all address bit into one
// operation code. Assumes the strobes are already synchronous to clk.
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    input  logic all_bit,
    output op_e  op
);

    // Map the strobe pattern to an operation.
    always_comb begin
        op = OP_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  op = OP_ACT;
                3'b101:  op = OP_RD;
                3'b100:  op = OP_WR;
                3'b110:  op = OP_BST;
                3'b010:  op = all_bit ? OP_PREA : OP_PRE;
                3'b001:  op = cke ? OP_AREF : OP_SREF;
                3'b000:  op = OP_LMR;
                default: op = OP_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdcmd_bank.sv
// State of one bank: idle, open with a row, or closing.
// Closing lasts until an ACTIVE sampled T_RP edges after the precharge
// edge can be accepted. Assumes the caller only raises act when the bank
// is idle; a precharge request is ignored unless the bank is open.
module sdcmd_bank
    import sdcmd_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int T_RP  = 3,
    localparam int CNT_W = $clog2(T_RP + 1)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             pre,
    input  logic [ROW_W-1:0] row,
    output bank_e            state,
    output logic [ROW_W-1:0] open_row
);

    localparam logic [CNT_W-1:0] RP_LOAD = CNT_W'(T_RP - 1);

    logic [CNT_W-1:0] rp_cnt;

    // Advance the bank state and the precharge delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= BK_IDLE;
            rp_cnt   <= '0;
            open_row <= '0;
        end else begin
            case (state)
                BK_IDLE: begin
                    if (act) begin
                        state    <= BK_OPEN;
                        open_row <= row;
                    end
                end
                BK_OPEN: begin
                    if (pre) begin
                        state  <= BK_CLOSING;
                        rp_cnt <= RP_LOAD;
                    end
                end
                BK_CLOSING: begin
                    if (rp_cnt <= CNT_W'(1)) begin
                        state <= BK_IDLE;
                    end else begin
                        rp_cnt <= rp_cnt - CNT_W'(1);
                    end
                end
                default: state <= BK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdcmd_burst.sv
// Tracks the one read or write burst that is in flight.
// Each burst lasts BURST_LEN/2 clocks. A new legal read or write replaces
// the current one. A terminate clears it. When an auto-precharge burst
// runs out, ap_fire pulses (combinationally) for the bank it belongs to.
module sdcmd_burst #(
    parameter int BURST_LEN = 4,
    parameter int BA_W      = 2,
    localparam int BEATS    = (BURST_LEN / 2 < 1) ? 1 : BURST_LEN / 2,
    localparam int CNT_W    = $clog2(BEATS + 1)
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            start_rd,
    input  logic            start_ap,
    input  logic [BA_W-1:0] start_bank,
    input  logic            stop,
    output logic            running,
    output logic            run_rd,
    output logic            run_ap,
    output logic            ap_fire,
    output logic [BA_W-1:0] ap_bank
);

    logic [CNT_W-1:0] cnt;

    // Load, clear or count down the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            run_rd  <= 1'b0;
            run_ap  <= 1'b0;
            ap_bank <= '0;
        end else if (start) begin
            cnt     <= CNT_W'(BEATS);
            run_rd  <= start_rd;
            run_ap  <= start_ap;
            ap_bank <= start_bank;
        end else if (stop) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Burst status and the end-of-burst auto-precharge pulse.
    always_comb begin
        running = (cnt != '0);
        ap_fire = (cnt == CNT_W'(1)) && run_ap && !stop;
    end

endmodule

// File: rtl/sdram_cmd_tracker.sv
// Device-side SDRAM command decoder with per-bank state tracking.
// Decodes the strobes each rising edge and checks the command against the
// bank and burst state. It updates the banks, and registers one report of
// the operation plus an illegal pulse. Assumes a single rank, and that
// inputs are already synchronous to clk.
module sdram_cmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int COL_W     = 9,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3,
    localparam int BA_W     = $clog2(NUM_BANKS)
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cke,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic [BA_W-1:0]             ba,
    input  logic [ADDR_W-1:0]           addr,
    output logic [3:0]                  op_code,
    output logic [BA_W-1:0]             op_bank,
    output logic [ADDR_W-1:0]           op_addr,
    output logic                        op_ap,
    output logic                        illegal,
    output logic [NUM_BANKS-1:0]        bank_open,
    output logic [NUM_BANKS*ADDR_W-1:0] open_rows,
    output logic                        [ADDR_W-1:0] mode_reg,
    output logic [ADDR_W-1:0]           ext_mode_reg
);

    op_e              op;
    bank_e            st [NUM_BANKS];
    bank_e            cur_st;
    logic             legal;
    logic             burst_run, burst_rd, burst_ap, ap_fire;
    logic [BA_W-1:0]  ap_bank;
    logic             start_burst, stop_burst;
    logic             is_ext_sel;
    logic [ADDR_W-1:0] addr_n;
    logic             has_bank;

    sdcmd_decode u_dec (
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .cke     (cke),
        .all_bit (addr[AP_BIT]),
        .op      (op)
    );

    assign cur_st     = st[ba];
    assign is_ext_sel = (ba == BA_W'(1));

    // Decide whether the sampled command is allowed in the present state.
    always_comb begin
        case (op)
            OP_ACT:          legal = cke && (cur_st == BK_IDLE);
            OP_RD, OP_WR:    legal = cke && (cur_st == BK_OPEN) && !(burst_run && burst_ap);
            OP_BST:          legal = cke && burst_run && burst_rd && !burst_ap;
            OP_PRE, OP_PREA: legal = cke;
            OP_LMR:          legal = cke && ((ba == '0) || is_ext_sel);
            default:         legal = 1'b1;
        endcase
    end

    assign start_burst = legal && ((op == OP_RD) || (op == OP_WR));
    assign stop_burst  = legal && (op == OP_BST);

    sdcmd_burst #(
        .BURST_LEN (BURST_LEN),
        .BA_W      (BA_W)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_burst),
        .start_rd   (op == OP_RD),
        .start_ap   (addr[AP_BIT]),
        .start_bank (ba),
        .stop       (stop_burst),
        .running    (burst_run),
        .run_rd     (burst_rd),
        .run_ap     (burst_ap),
        .ap_fire    (ap_fire),
        .ap_bank    (ap_bank)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic act_b, pre_b;
            logic [ADDR_W-1:0] row_b;

            assign act_b = legal && (op == OP_ACT) && (ba == BA_W'(b));
            assign pre_b = (legal && (op == OP_PRE) && (ba == BA_W'(b)))
                         || (legal && (op == OP_PREA))
                         || (ap_fire && (ap_bank == BA_W'(b)));

            sdcmd_bank #(
                .ROW_W (ADDR_W),
                .T_RP  (T_RP)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .act      (act_b),
                .pre      (pre_b),
                .row      (addr),
                .state    (st[b]),
                .open_row (row_b)
            );

            assign bank_open[b]                   = (st[b] == BK_OPEN);
            assign open_rows[b*ADDR_W +: ADDR_W]  = row_b;
        end
    endgenerate

    // Select what the address field of the report carries.
    always_comb begin
        addr_n   = '0;
        has_bank = 1'b0;
        case (op)
            OP_ACT, OP_LMR: begin
                addr_n   = addr;
                has_bank = 1'b1;
            end
            OP_RD, OP_WR: begin
                addr_n   = ADDR_W'(addr[COL_W-1:0]);
                has_bank = 1'b1;
            end
            OP_PRE: has_bank = 1'b1;
            default: ;
        endcase
    end

    // Register the operation report and the illegal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_code <= '0;
            op_bank <= '0;
            op_addr <= '0;
            op_ap   <= 1'b0;
            illegal <= 1'b0;
        end else begin
            op_code <= op;
            op_bank <= has_bank ? ba : '0;
            op_addr <= addr_n;
            op_ap   <= ((op == OP_RD) || (op == OP_WR)) && addr[AP_BIT];
            illegal <= !legal;
        end
    end

    // Capture mode-register loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_reg     <= '0;
            ext_mode_reg <= '0;
        end else if (legal && (op == OP_LMR)) begin
            if (is_ext_sel) ext_mode_reg <= addr;
            else            mode_reg     <= addr;
        end
    end

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
// Checker for sdram_cmd_tracker. It watches only the ports, and is bound
// to every instance of the tracker.
module sdram_cmd_tracker_chk
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int BA_W      = 2
)(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cke,
    input logic [3:0]                  op_code,
    input logic [BA_W-1:0]             op_bank,
    input logic                        op_ap,
    input logic                        illegal,
    input logic [NUM_BANKS-1:0]        bank_open,
    input logic [NUM_BANKS*ADDR_W-1:0] open_rows,
    input logic [ADDR_W-1:0]           mode_reg,
    input logic [ADDR_W-1:0]           ext_mode_reg
);

    AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_ACT && !illegal) |-> bank_open[op_bank]); // R2

    AST_PREA_CLOSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_PREA && !illegal) |-> (bank_open == '0)); // R3

    AST_AP_ONLY_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        op_ap |-> (op_code == OP_RD || op_code == OP_WR)); // R4

    AST_CKE_LOW_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cke) == 1'b0 && op_code inside {OP_ACT, OP_RD, OP_WR, OP_BST,
                                               OP_PRE, OP_PREA, OP_LMR}) |-> illegal); // R7

    AST_ILLEGAL_KEEPS_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $stable(open_rows)); // R8

    AST_MODE_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_code == OP_LMR && !illegal) |-> ($stable(mode_reg) && $stable(ext_mode_reg))); // R9

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke          (cke),
    .op_code      (op_code),
    .op_bank      (op_bank),
    .op_ap        (op_ap),
    .illegal      (illegal),
    .bank_open    (bank_open),
    .open_rows    (open_rows),
    .mode_reg     (mode_reg),
    .ext_mode_reg (ext_mode_reg)
);

// File: tb/tb_sdram_cmd_tracker.sv
module tb_sdram_cmd_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int AW = 13;

    logic clk = 1'b0;
    logic rst_n, cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0] ba;
    logic [AW-1:0] addr;
    logic [3:0] op_code;
    logic [1:0] op_bank;
    logic [AW-1:0] op_addr;
    logic op_ap, illegal;
    logic [NB-1:0] bank_open;
    logic [NB*AW-1:0] open_rows;
    logic [AW-1:0] mode_reg, ext_mode_reg;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_tracker #(.NUM_BANKS(NB), .ADDR_W(AW), .COL_W(9), .AP_BIT(10),
                        .BURST_LEN(4), .T_RP(3)) dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .op_code(op_code),
        .op_bank(op_bank), .op_addr(op_addr), .op_ap(op_ap), .illegal(illegal),
        .bank_open(bank_open), .open_rows(open_rows), .mode_reg(mode_reg),
        .ext_mode_reg(ext_mode_reg));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; return at the next falling edge, with results due.
    task automatic issue(input logic c, input logic r, input logic s, input logic w,
                         input logic k, input logic [1:0] b, input logic [AW-1:0] a);
        cs_n = c; ras_n = r; cas_n = s; we_n = w; cke = k; ba = b; addr = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nop();                              issue(0,1,1,1,1,2'd0,'0); endtask
    task automatic act(input logic [1:0] b, input logic [AW-1:0] row); issue(0,0,1,1,1,b,row); endtask
    task automatic rd(input logic [1:0] b, input logic [AW-1:0] a);    issue(0,1,0,1,1,b,a); endtask
    task automatic wr(input logic [1:0] b, input logic [AW-1:0] a);    issue(0,1,0,0,1,b,a); endtask
    task automatic bst();                              issue(0,1,1,0,1,2'd0,'0); endtask
    task automatic pre(input logic [1:0] b);           issue(0,0,1,0,1,b,13'h0000); endtask
    task automatic lmr(input logic [1:0] b, input logic [AW-1:0] a);   issue(0,0,0,0,1,b,a); endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; cke = 1; ba = 0; addr = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [3:0] exp_op(input logic c, input logic r, input logic s,
                                          input logic w, input logic k, input logic a10);
        if (c) return 4'd0;
        case ({r, s, w})
            3'b011: return 4'd1;
            3'b101: return 4'd2;
            3'b100: return 4'd3;
            3'b110: return 4'd4;
            3'b010: return a10 ? 4'd6 : 4'd5;
            3'b001: return k ? 4'd7 : 4'd8;
            3'b000: return 4'd9;
            default: return 4'd0;
        endcase
    endfunction

    // With all banks idle and no burst running.
    function automatic logic exp_ill(input logic [3:0] o, input logic k);
        case (o)
            4'd1, 4'd6, 4'd9: return !k;
            4'd2, 4'd3, 4'd4: return 1'b1;
            default:          return 1'b0;
        endcase
    endfunction

    function automatic logic [AW-1:0] row_of(input int b);
        return open_rows[b*AW +: AW];
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        // R10: state after reset
        chk("R10 op_code", op_code, 0);
        chk("R10 illegal", illegal, 0);
        chk("R10 bank_open", bank_open, 0);
        chk("R10 mode_reg", mode_reg, 0);

        // R1/R7: sweep every strobe pattern and cke from an idle device
        for (int v = 0; v < 32; v++) begin
            logic [3:0] eo;
            do_reset();
            eo = exp_op(v[4], v[3], v[2], v[1], v[0], 1'b1);
            issue(v[4], v[3], v[2], v[1], v[0], 2'd0, 13'h0400);
            chk("R1 sweep op_code", op_code, eo);
            chk("R7 sweep illegal", illegal, exp_ill(eo, v[0]));
            chk("R7 sweep bank_open", bank_open, (eo == 4'd1 && v[0]) ? 4'b0001 : 4'b0000);
            chk("R9 sweep mode_reg", mode_reg, (eo == 4'd9 && v[0]) ? 13'h0400 : 13'h0);
        end

        do_reset();
        // R2: open all banks
        act(0, 13'h0ABC);
        chk("R2 op", op_code, 1); chk("R2 row", op_addr, 13'h0ABC); chk("R2 open", bank_open, 4'b0001);
        act(1, 13'h1111); act(2, 13'h0222); act(3, 13'h1FFF);
        chk("R2 all open", bank_open, 4'hF);
        chk("R2 row1", row_of(1), 13'h1111);
        chk("R2 row3", row_of(3), 13'h1FFF);
        chk("R2 op_bank", op_bank, 3);

        // R1: deselect with LMR-like strobes has no effect
        issue(1, 0, 0, 0, 1, 2'd0, 13'h0777);
        chk("R1 deselect op", op_code, 0);
        chk("R1 deselect banks", bank_open, 4'hF);
        chk("R1 deselect mode", mode_reg, 0);

        // R8: ACTIVE to an open bank
        act(1, 13'h0555);
        chk("R8 act open illegal", illegal, 1);
        chk("R8 row kept", row_of(1), 13'h1111);

        // R4/R6: read without auto-precharge, then terminate
        rd(2, 13'h09A5);
        chk("R4 rd op", op_code, 2); chk("R4 rd col", op_addr, 13'h01A5);
        chk("R4 rd ap", op_ap, 0); chk("R4 rd legal", illegal, 0);
        bst();
        chk("R6 bst read legal", illegal, 0);
        wr(0, 13'h0033);
        chk("R4 wr op", op_code, 3);
        bst();
        chk("R6 bst write illegal", illegal, 1);
        nop(); nop();
        bst();
        chk("R6 bst idle illegal", illegal, 1);
        chk("R4 no-ap keeps open", bank_open, 4'hF);

        // R4/R6/R5: auto-precharge read on bank 3
        rd(3, 13'h0410);
        chk("R4 ap flag", op_ap, 1); chk("R4 ap col", op_addr, 13'h0010);
        bst();
        chk("R6 bst ap-read illegal", illegal, 1);
        chk("R4 still open mid burst", bank_open, 4'hF);
        nop();
        chk("R4 ap closes bank3", bank_open, 4'h7);
        act(3, 13'h0777);
        chk("R5 act +1 illegal", illegal, 1);
        act(3, 13'h0777);
        chk("R5 act +2 illegal", illegal, 1);
        act(3, 13'h0777);
        chk("R5 act +3 legal", illegal, 0);
        chk("R5 bank3 reopened", bank_open, 4'hF);

        // R8: read during an auto-precharge burst
        rd(3, 13'h0400);
        rd(0, 13'h0001);
        chk("R8 rd during ap burst", illegal, 1);
        nop();
        chk("R8/R4 bank3 closed", bank_open, 4'h7);

        // R3: single-bank precharge and precharge of an idle bank
        pre(1);
        chk("R3 pre one", bank_open, 4'h5);
        chk("R3 pre op", op_code, 5);
        pre(1);
        chk("R3 pre closing no-op", illegal, 0);
        chk("R3 pre closing banks", bank_open, 4'h5);

        // R5: manual precharge then reactivation
        pre(0);
        chk("R5 pre0", bank_open, 4'h4);
        act(0, 13'h0321); chk("R5 manual +1", illegal, 1);
        act(0, 13'h0321); chk("R5 manual +2", illegal, 1);
        act(0, 13'h0321); chk("R5 manual +3", illegal, 0);
        chk("R5 row0", row_of(0), 13'h0321);

        // R3: precharge all ignores the bank bits
        issue(0, 0, 1, 0, 1, 2'd1, 13'h0400);
        chk("R3 prea op", op_code, 6);
        chk("R3 prea closes", bank_open, 4'h0);
        chk("R3 prea legal", illegal, 0);

        // R8: read to an idle bank
        repeat (3) nop();
        rd(2, 13'h0005);
        chk("R8 rd idle", illegal, 1);
        chk("R8 rd idle banks", bank_open, 4'h0);

        // R9: mode registers
        lmr(0, 13'h0033);
        chk("R9 base", mode_reg, 13'h0033);
        lmr(1, 13'h0002);
        chk("R9 ext", ext_mode_reg, 13'h0002);
        chk("R9 base kept", mode_reg, 13'h0033);
        lmr(2, 13'h0FFF);
        chk("R9 bad ba illegal", illegal, 1);
        chk("R9 bad ba base", mode_reg, 13'h0033);
        chk("R9 bad ba ext", ext_mode_reg, 13'h0002);

        // R7: cke low
        issue(0, 0, 0, 0, 0, 2'd0, 13'h0111);
        chk("R7 lmr cke low", illegal, 1);
        chk("R7 lmr cke low mode", mode_reg, 13'h0033);
        issue(0, 0, 0, 1, 0, 2'd0, 13'h0);
        chk("R7 self refresh op", op_code, 8);
        chk("R7 self refresh legal", illegal, 0);
        issue(0, 0, 0, 1, 1, 2'd0, 13'h0);
        chk("R1 auto refresh op", op_code, 7);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule